// File: doc/BRIEF.md
# Multilane I2S Receiver with Shared Bit Counter

This block takes a bank of I2S serial data lines that all run from one bit clock and one word-select line, and turns each line into a parallel left sample and a parallel right sample. The bit clock, word select and every data line are brought into the system clock domain through two-stage synchronisers. Rising edges of the synchronised bit clock are found inside the block, and serial data is sampled on those edges. The bit clock must therefore be slow enough for the system clock to oversample it.

The logic that finds word boundaries is built once. It consists of a saturating bit counter, a one-hot slot decode and the acquisition and handshake flags, and every lane uses it. Each lane holds only an assembly register and its two output holding registers. When a right word completes, all lanes present a left and right pair taken from the same frame, and a single strobe marks it.

Top module: `i2s_multilane_rx`

## Requirements
- R1: While reset is asserted and directly after it, every left and right output word is zero and `pair_valid` is low.
- R2: Words are sent MSB first. The bit sampled on the bit-clock rising edge where a word-select change is first seen is the LSB of the word that is ending. The MSB of the next word is sampled on the rising edge that follows.
- R3: Word select low (0) carries the left channel and high (1) carries the right channel. A completed left word is loaded into that lane's left output when word select goes from 0 to 1. The right outputs do not change at that moment.
- R4: `pair_valid` is high for exactly one system clock, in the same cycle that the right outputs of all lanes take the newly completed right words. It is raised only if a left word has been loaded since the stream was acquired.
- R5: Bits past the WIDTH-th bit of a half-frame are discarded, and the output word is the first WIDTH bits received.
- R6: If a half-frame has fewer than WIDTH bits, the received bits fill the word from its MSB down and the remaining low bits are zero.
- R7: The first word-select change after reset only sets word alignment. No word is loaded and no `pair_valid` is raised until a whole left half-frame and a whole right half-frame have been received after it.
- R8: The right outputs change only in the cycle where `pair_valid` is high. The left outputs never change in that cycle.
- R9: Each lane's outputs are built only from that lane's own data line. Lane g occupies bits [g*WIDTH +: WIDTH] of the packed output buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must oversample the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_in | input | 1 | Shared serial bit clock, asynchronous |
| ws_in | input | 1 | Shared word select, 0 = left, 1 = right |
| sd_in | input | LANES | One serial data line per lane |
| left_data | output | LANES*WIDTH | Packed left words, lane g at [g*WIDTH +: WIDTH] |
| right_data | output | LANES*WIDTH | Packed right words, same packing |
| pair_valid | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
Two things fall on the same bit-clock edge: the last bit of a word is captured, and that word is loaded into a holding register. On that edge the bit counter also restarts for the next word. The bench drives frames whose only set bit is the LSB, and frames whose only set bit is the MSB. An LSB that is dropped or shifted at the boundary then shows up as a wrong word on the very next pair. A frame of all ones is also driven. Scoreboard entries for half-frames that are too long or too short check that the counter restarts from zero even when it has saturated, or has not reached WIDTH, at the moment word select changes.

// File: rtl/i2s_multilane_rx.sv
module i2s_multilane_rx #(
  parameter int LANES = 8,
  parameter int WIDTH = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck_in,
  input  logic                     ws_in,
  input  logic [LANES-1:0]         sd_in,
  output logic [LANES*WIDTH-1:0]   left_data,
  output logic [LANES*WIDTH-1:0]   right_data,
  output logic                     pair_valid
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);

  logic [2:0]       sck_q;
  logic [1:0]       ws_q;
  logic [LANES-1:0] sd_q1, sd_q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q1 <= '0;
      sd_q2 <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_in};
      ws_q  <= {ws_q[0], ws_in};
      sd_q1 <= sd_in;
      sd_q2 <= sd_q1;
    end
  end

  wire rise   = sck_q[1] & ~sck_q[2];
  wire ws_now = ws_q[1];

  logic          ws_prev, armed, left_ok;
  logic [CW-1:0] bit_cnt;

  wire boundary = rise && (ws_now != ws_prev);
  wire latch_l  = boundary && armed && !ws_prev;
  wire latch_r  = boundary && armed && ws_prev && left_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_prev    <= 1'b0;
      armed      <= 1'b0;
      left_ok    <= 1'b0;
      bit_cnt    <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= latch_r;
      if (rise) begin
        ws_prev <= ws_now;
        armed   <= armed | boundary;
        if (latch_l) left_ok <= 1'b1;
        if (boundary)          bit_cnt <= '0;
        else if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  logic [WIDTH-1:0] slot;
  always_comb begin
    for (int b = 0; b < WIDTH; b++)
      slot[b] = (bit_cnt == CW'(WIDTH - 1 - b));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIDTH-1:0] asm_q;
    wire  [WIDTH-1:0] word = (asm_q & ~slot) | (slot & {WIDTH{sd_q2[g]}});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        asm_q                       <= '0;
        left_data[g*WIDTH +: WIDTH]  <= '0;
        right_data[g*WIDTH +: WIDTH] <= '0;
      end else if (rise) begin
        asm_q <= boundary ? '0 : word;
        if (latch_l) left_data[g*WIDTH +: WIDTH]  <= word;
        if (latch_r) right_data[g*WIDTH +: WIDTH] <= word;
      end
    end
  end
endmodule

// File: rtl/i2s_multilane_rx_chk.sv
module i2s_multilane_rx_chk #(
  parameter int LANES = 8,
  parameter int WIDTH = 24,
  parameter int CW    = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pair_valid,
  input logic                   armed,
  input logic [CW-1:0]          bit_cnt,
  input logic [LANES*WIDTH-1:0] left_data,
  input logic [LANES*WIDTH-1:0] right_data
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> $stable(right_data));

  a_r8_left_apart: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $stable(left_data));

  a_r7_no_pair_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !pair_valid);

  a_r5_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= WIDTH);
endmodule

bind i2s_multilane_rx i2s_multilane_rx_chk #(
  .LANES(LANES), .WIDTH(WIDTH), .CW($clog2(WIDTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .armed(armed),
  .bit_cnt(bit_cnt), .left_data(left_data), .right_data(right_data)
);

// File: tb/test_i2s_multilane_rx.sv
module test_i2s_multilane_rx;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int WIDTH = 24;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, sck_in = 1'b0, ws_in = 1'b0;
  logic [LANES-1:0] sd_in = '0;
  logic [LANES*WIDTH-1:0] left_data, right_data;
  logic pair_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_multilane_rx #(.LANES(LANES), .WIDTH(WIDTH)) i_i2s_multilane_rx (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .left_data(left_data), .right_data(right_data), .pair_valid(pair_valid)
  );

  typedef struct {
    logic [LANES*WIDTH-1:0] l;
    logic [LANES*WIDTH-1:0] r;
    string tag;
  } pair_t;

  pair_t exp_q[$];
  int errors = 0, checks = 0, pairs = 0;
  bit done = 1'b0;
  logic [LANES*WIDTH-1:0] last_r = '0;

  task automatic check(input bit ok, input string req, input logic [LANES*WIDTH-1:0] act,
                       input logic [LANES*WIDTH-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic sck_bit(input logic ws, input logic [LANES-1:0] d);
    @(negedge clk);
    sck_in = 1'b0; ws_in = ws; sd_in = d;
    repeat (H) @(negedge clk);
    sck_in = 1'b1;
    repeat (H - 1) @(negedge clk);
  endtask

  function automatic logic [WIDTH-1:0] keep_top(input logic [WIDTH-1:0] w, input int n);
    logic [WIDTH-1:0] r = '0;
    for (int b = 0; b < WIDTH; b++)
      if (WIDTH - 1 - b < n) r[b] = w[b];
    return r;
  endfunction

  // mode 0 random, 1 LSB only, 2 MSB only, 3 all ones
  task automatic send_frame(input int nl, input int nr, input int mode, input string tag);
    logic [WIDTH-1:0] w [2][LANES];
    pair_t e;
    int n;
    logic [LANES-1:0] d;
    for (int g = 0; g < LANES; g++)
      for (int h = 0; h < 2; h++) begin
        case (mode)
          1: w[h][g] = WIDTH'(1);
          2: w[h][g] = {1'b1, {(WIDTH-1){1'b0}}};
          3: w[h][g] = '1;
          default: w[h][g] = WIDTH'($urandom);
        endcase
        if (h == 0) e.l[g*WIDTH +: WIDTH] = keep_top(w[h][g], nl);
        else        e.r[g*WIDTH +: WIDTH] = keep_top(w[h][g], nr);
      end
    e.tag = tag;
    exp_q.push_back(e);
    for (int h = 0; h < 2; h++) begin
      n = (h == 0) ? nl : nr;
      for (int j = 0; j < n; j++) begin
        for (int g = 0; g < LANES; g++)
          d[g] = (j < WIDTH) ? w[h][g][WIDTH-1-j] : 1'($urandom);
        sck_bit((j == n - 1) ? logic'(h == 0) : logic'(h), d);
        if (h == 1 && j == 0) begin
          // R3: left loaded at the 0->1 change, right untouched (R8)
          check(left_data == e.l, {"R3 left ", tag}, left_data, e.l);
          check(right_data == last_r, {"R8 right hold ", tag}, right_data, last_r);
        end
      end
    end
    last_r = e.r;
  endtask

  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      pair_t e;
      pairs++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected pair_valid", right_data, '0);
      end else begin
        e = exp_q.pop_front();
        // R9: per-lane fields compared individually
        for (int g = 0; g < LANES; g++) begin
          check(left_data[g*WIDTH +: WIDTH] == e.l[g*WIDTH +: WIDTH],
                $sformatf("R9 lane %0d left %s", g, e.tag),
                left_data[g*WIDTH +: WIDTH], e.l[g*WIDTH +: WIDTH]);
          check(right_data[g*WIDTH +: WIDTH] == e.r[g*WIDTH +: WIDTH],
                $sformatf("R2 lane %0d right %s", g, e.tag),
                right_data[g*WIDTH +: WIDTH], e.r[g*WIDTH +: WIDTH]);
        end
      end
      @(negedge clk);
      check(!pair_valid, "R4 single cycle", {{(LANES*WIDTH-1){1'b0}}, pair_valid}, '0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(left_data == '0 && right_data == '0 && !pair_valid, "R1 reset",
          left_data | right_data, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(left_data == '0 && right_data == '0 && !pair_valid, "R1 after reset",
          left_data | right_data, '0);
    // R7: preamble right half only acquires alignment
    for (int j = 0; j < WIDTH; j++) sck_bit((j == WIDTH - 1) ? 1'b0 : 1'b1, LANES'($urandom));
    repeat (10) @(negedge clk);
    check(pairs == 0 && right_data == '0, "R7 no load during acquisition",
          right_data, '0);
    send_frame(WIDTH, WIDTH, 1, "lsb only R2");
    send_frame(WIDTH, WIDTH, 2, "msb only R2");
    send_frame(WIDTH, WIDTH, 3, "all ones R2");
    for (int k = 0; k < 4; k++) send_frame(WIDTH, WIDTH, 0, "random R2");
    send_frame(32, 32, 0, "long R5");
    send_frame(WIDTH + 1, 40, 3, "long ones R5");
    send_frame(16, 16, 0, "short R6");
    send_frame(20, 9, 3, "short ones R6");
    send_frame(30, 18, 0, "mixed R5 R6");
    send_frame(WIDTH, WIDTH, 0, "recover R2");
    sck_bit(1'b0, '0);
    sck_bit(1'b0, '0);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4 all pairs seen", LANES*WIDTH'(exp_q.size()), '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule